// File: doc/BRIEF.md
# Tiled Surface Fence Legality Checker

This block judges whether a request to lay a graphics surface out in a tiled format is legal for the memory controller generation in use. A request names the generation, the tiling format (linear, X-major or Y-major), the row pitch in bytes, the object size, and the size and base offset of the aperture region the object now occupies. A flag says whether the hardware uses the narrow form of Y tiles. The block answers with two verdicts. The first says whether the pitch and size obey the generation's tiling rules. The second says whether the current aperture placement can be covered by a fence region.

The pitch verdict is a single-cycle rule evaluation. The fence verdict on the two legacy generations needs the smallest power-of-two fence region that covers the object. That region starts at a floor that depends on the generation and is doubled once per clock until it covers the object. A one-cycle done pulse marks the moment both verdicts are valid. The verdicts then hold until the next done pulse. A start pulse that arrives while a judgement is running is dropped.

Top module: `tile_fence_judge`

## Requirements
- R1: With tiling format linear (code 0), both stride_ok and fence_ok are 1, whatever the other inputs hold.
- R2: The tile width is 128 bytes when the generation is legacy-A (code 0), or when the format is Y-major (code 2, and code 3 treated alike) with narrow_y set. In every other case it is 512 bytes.
- R3: On the modern generation (codes 2 and 3), stride_ok is 1 exactly when stride shifted right by 7 is at most MAX_PITCH (default 127) and stride is a multiple of the tile width. The object size has no effect.
- R4: On legacy-A and legacy-B (code 1), stride_ok requires a stride of at most LEGACY_STRIDE_MAX (default 8192), at least the tile width, and a power of two.
- R5: On the legacy generations, stride_ok also requires obj_size to be at most SIZE_LIMIT (default 64) shifted left by 20 on legacy-B, or by 19 on legacy-A.
- R6: On the modern generation, fence_ok is always 1.
- R7: On legacy generations with a tiled format, a fence region starts at 512 KiB (legacy-A) or 1 MiB (legacy-B) and doubles until it is at least obj_size. fence_ok is 1 only when all of the following hold: region_size equals that region; region_offset is a multiple of it; and region_offset has no bits set outside the generation's start mask (default 0x07F80000 for legacy-A, 0x0FF00000 for legacy-B). If the doubling reaches the top address bit without covering the object, fence_ok is 0.
- R8: A start sampled at clock edge n makes done high for exactly one cycle, following edge n+1+k. Here k is the number of doublings R7 needs; k is 0 for linear or modern requests.
- R9: After reset, done, stride_ok and fence_ok are 0. stride_ok and fence_ok change only together with a done pulse.
- R10: A start that arrives while a judgement is running is ignored. A start in the done cycle itself is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; captures all request inputs when idle |
| gen_sel | input | 2 | 0 legacy-A, 1 legacy-B, 2 or 3 modern |
| tile_mode | input | 2 | 0 linear, 1 X-major, 2 or 3 Y-major |
| narrow_y | input | 1 | Hardware uses 128-byte-wide Y tiles |
| stride | input | 16 | Row pitch in bytes |
| obj_size | input | 32 | Object size in bytes |
| region_size | input | 32 | Size of the currently allocated aperture region |
| region_offset | input | 32 | Base offset of that region |
| done | output | 1 | One-cycle pulse: verdicts valid |
| stride_ok | output | 1 | Pitch and size legal for the format |
| fence_ok | output | 1 | Placement can be fenced |

## Verification
The bound checker watches several properties on every cycle. The linear and modern verdicts must pass. The done pulse must last exactly one cycle and must follow a busy cycle. The verdicts must stay still between pulses. The captured request must not move while a judgement runs. Any legacy fence pass must name a power-of-two region that covers the object and aligns the offset. The exact pitch arithmetic, the generation size limits, the doubling latency, the saturation case and the dropped or accepted start pulses can only be shown by the bench. It does this with its vector table and its directed scenarios.

// File: rtl/tfj_pkg.sv
package tfj_pkg;

    localparam int TFJ_STRIDE_W = 16;
    localparam int TFJ_ADDR_W   = 32;

    typedef enum logic [1:0] {
        GEN_LEG_A   = 2'd0,
        GEN_LEG_B   = 2'd1,
        GEN_MODERN  = 2'd2,
        GEN_MODERN2 = 2'd3
    } gen_e;

    typedef enum logic [1:0] {
        TM_LINEAR = 2'd0,
        TM_XMAJ   = 2'd1,
        TM_YMAJ   = 2'd2,
        TM_YMAJ2  = 2'd3
    } tmode_e;

    typedef struct packed {
        gen_e                    gen;
        tmode_e                  mode;
        logic                    narrow_y;
        logic [TFJ_STRIDE_W-1:0] stride;
        logic [TFJ_ADDR_W-1:0]   obj_size;
        logic [TFJ_ADDR_W-1:0]   reg_size;
        logic [TFJ_ADDR_W-1:0]   reg_off;
    } req_t;

    function automatic logic is_modern(gen_e g);
        return g[1];
    endfunction

    function automatic logic is_y_type(tmode_e m);
        return m[1];
    endfunction

    function automatic logic is_pow2_stride(logic [TFJ_STRIDE_W-1:0] v);
        return (v & (v - 1'b1)) == '0;
    endfunction

endpackage

// File: rtl/tfj_stride_rule.sv
module tfj_stride_rule
    import tfj_pkg::*;
#(
    parameter int MAX_PITCH         = 127,
    parameter int LEGACY_STRIDE_MAX = 8192,
    parameter int SIZE_LIMIT        = 64,
    parameter int NARROW_TILE       = 128,
    parameter int WIDE_TILE         = 512
) (
    input  req_t req,
    output logic ok
);
    localparam logic [TFJ_STRIDE_W-1:0] PITCH_CAP  = TFJ_STRIDE_W'(MAX_PITCH);
    localparam logic [TFJ_STRIDE_W:0]   LEG_CAP    = (TFJ_STRIDE_W+1)'(LEGACY_STRIDE_MAX);
    localparam logic [63:0]             LIM_LEG_B  = 64'(SIZE_LIMIT) << 20;
    localparam logic [63:0]             LIM_LEG_A  = 64'(SIZE_LIMIT) << 19;

    logic [TFJ_STRIDE_W-1:0] tile_w;
    logic                    modern_ok;
    logic                    legacy_ok;
    logic [63:0]             size_cap;

    always_comb begin
        if (req.gen == GEN_LEG_A || (is_y_type(req.mode) && req.narrow_y))
            tile_w = TFJ_STRIDE_W'(NARROW_TILE);
        else
            tile_w = TFJ_STRIDE_W'(WIDE_TILE);

        size_cap  = (req.gen == GEN_LEG_B) ? LIM_LEG_B : LIM_LEG_A;

        modern_ok = ((req.stride >> 7) <= PITCH_CAP)
                 && ((req.stride & (tile_w - 1'b1)) == '0);

        legacy_ok = ({1'b0, req.stride} <= LEG_CAP)
                 && (req.stride >= tile_w)
                 && is_pow2_stride(req.stride)
                 && ({32'b0, req.obj_size} <= size_cap);

        if (req.mode == TM_LINEAR)
            ok = 1'b1;
        else if (is_modern(req.gen))
            ok = modern_ok;
        else
            ok = legacy_ok;
    end
endmodule

// File: rtl/tfj_fence_walk.sv
module tfj_fence_walk
    import tfj_pkg::*;
#(
    parameter int FLOOR_A = 32'h0008_0000,
    parameter int FLOOR_B = 32'h0010_0000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  advance,
    input  gen_e                  gen,
    input  logic [TFJ_ADDR_W-1:0] obj_size,
    output logic [TFJ_ADDR_W-1:0] fsize,
    output logic                  covered,
    output logic                  saturated
);
    localparam logic [TFJ_ADDR_W-1:0] START_A = TFJ_ADDR_W'(FLOOR_A);
    localparam logic [TFJ_ADDR_W-1:0] START_B = TFJ_ADDR_W'(FLOOR_B);

    always_ff @(posedge clk) begin
        if (rst)
            fsize <= '0;
        else if (load)
            fsize <= (gen == GEN_LEG_B) ? START_B : START_A;
        else if (advance)
            fsize <= fsize << 1;
    end

    assign covered   = (fsize >= obj_size);
    assign saturated = fsize[TFJ_ADDR_W-1];
endmodule

// File: rtl/tfj_fence_rule.sv
module tfj_fence_rule
    import tfj_pkg::*;
#(
    parameter int START_MASK_A = 32'h07F8_0000,
    parameter int START_MASK_B = 32'h0FF0_0000
) (
    input  req_t                  req,
    input  logic [TFJ_ADDR_W-1:0] fsize,
    input  logic                  covered,
    output logic                  ok
);
    localparam logic [TFJ_ADDR_W-1:0] MASK_A = TFJ_ADDR_W'(START_MASK_A);
    localparam logic [TFJ_ADDR_W-1:0] MASK_B = TFJ_ADDR_W'(START_MASK_B);

    logic [TFJ_ADDR_W-1:0] mask;
    logic                  place_ok;

    always_comb begin
        mask     = (req.gen == GEN_LEG_B) ? MASK_B : MASK_A;
        place_ok = covered
                && (req.reg_size == fsize)
                && ((req.reg_off & (fsize - 1'b1)) == '0)
                && ((req.reg_off & ~mask) == '0);
        if (req.mode == TM_LINEAR || is_modern(req.gen))
            ok = 1'b1;
        else
            ok = place_ok;
    end
endmodule

// File: rtl/tile_fence_judge.sv
module tile_fence_judge
    import tfj_pkg::*;
#(
    parameter int MAX_PITCH         = 127,
    parameter int LEGACY_STRIDE_MAX = 8192,
    parameter int SIZE_LIMIT        = 64,
    parameter int FLOOR_A           = 32'h0008_0000,
    parameter int FLOOR_B           = 32'h0010_0000,
    parameter int START_MASK_A      = 32'h07F8_0000,
    parameter int START_MASK_B      = 32'h0FF0_0000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [1:0]              gen_sel,
    input  logic [1:0]              tile_mode,
    input  logic                    narrow_y,
    input  logic [TFJ_STRIDE_W-1:0] stride,
    input  logic [TFJ_ADDR_W-1:0]   obj_size,
    input  logic [TFJ_ADDR_W-1:0]   region_size,
    input  logic [TFJ_ADDR_W-1:0]   region_offset,
    output logic                    done,
    output logic                    stride_ok,
    output logic                    fence_ok
);
    typedef enum logic {ST_IDLE, ST_RUN} state_e;

    state_e                state;
    req_t                  req_q;
    logic                  busy;
    logic                  load;
    logic                  settle;
    logic                  skip_walk;
    logic                  stride_res;
    logic                  fence_res;
    logic [TFJ_ADDR_W-1:0] fsize;
    logic                  covered;
    logic                  saturated;

    assign busy      = (state == ST_RUN);
    assign load      = start && !busy;
    assign skip_walk = (req_q.mode == TM_LINEAR) || is_modern(req_q.gen);
    assign settle    = skip_walk || covered || saturated;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            req_q     <= '0;
            done      <= 1'b0;
            stride_ok <= 1'b0;
            fence_ok  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                state          <= ST_RUN;
                req_q.gen      <= gen_e'(gen_sel);
                req_q.mode     <= tmode_e'(tile_mode);
                req_q.narrow_y <= narrow_y;
                req_q.stride   <= stride;
                req_q.obj_size <= obj_size;
                req_q.reg_size <= region_size;
                req_q.reg_off  <= region_offset;
            end else if (busy && settle) begin
                state     <= ST_IDLE;
                done      <= 1'b1;
                stride_ok <= stride_res;
                fence_ok  <= fence_res;
            end
        end
    end

    tfj_stride_rule #(
        .MAX_PITCH         (MAX_PITCH),
        .LEGACY_STRIDE_MAX (LEGACY_STRIDE_MAX),
        .SIZE_LIMIT        (SIZE_LIMIT),
        .NARROW_TILE       (128),
        .WIDE_TILE         (512)
    ) u_stride (
        .req (req_q),
        .ok  (stride_res)
    );

    tfj_fence_walk #(
        .FLOOR_A (FLOOR_A),
        .FLOOR_B (FLOOR_B)
    ) u_walk (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .advance   (busy && !settle),
        .gen       (gen_e'(gen_sel)),
        .obj_size  (req_q.obj_size),
        .fsize     (fsize),
        .covered   (covered),
        .saturated (saturated)
    );

    tfj_fence_rule #(
        .START_MASK_A (START_MASK_A),
        .START_MASK_B (START_MASK_B)
    ) u_fence (
        .req     (req_q),
        .fsize   (fsize),
        .covered (covered),
        .ok      (fence_res)
    );
endmodule

// File: rtl/tfj_judge_checker.sv
module tfj_judge_checker
    import tfj_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic done,
    input logic stride_ok,
    input logic fence_ok,
    input logic busy,
    input req_t req
);
    // R1: linear requests pass both verdicts
    assert_linear_pass_R1: assert property (@(posedge clk) disable iff (rst)
        (done && req.mode == TM_LINEAR) |-> (stride_ok && fence_ok));

    // R6: modern generation never fails the fence verdict
    assert_modern_fence_R6: assert property (@(posedge clk) disable iff (rst)
        (done && req.gen[1]) |-> fence_ok);

    // R7: a legacy fence pass names a covering, aligned power-of-two region
    assert_fence_region_R7: assert property (@(posedge clk) disable iff (rst)
        (done && fence_ok && !req.gen[1] && req.mode != TM_LINEAR) |->
        ($countones(req.reg_size) == 1 && req.reg_size >= req.obj_size
         && (req.reg_off & (req.reg_size - 1)) == '0));

    // R8: done lasts one cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: done only ends a running judgement
    assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    // R9: verdicts move only with done
    assert_hold_verdict_R9: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(stride_ok) && $stable(fence_ok)));

    // R10: captured request frozen while busy
    assert_ignore_start_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(req));
endmodule

bind tile_fence_judge tfj_judge_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .done      (done),
    .stride_ok (stride_ok),
    .fence_ok  (fence_ok),
    .busy      (busy),
    .req       (req_q)
);

// File: tb/sim_tile_fence_judge.sv
module sim_tile_fence_judge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  gen_sel = '0;
    logic [1:0]  tile_mode = '0;
    logic        narrow_y = 1'b0;
    logic [15:0] stride = '0;
    logic [31:0] obj_size = '0;
    logic [31:0] region_size = '0;
    logic [31:0] region_offset = '0;
    logic        done, stride_ok, fence_ok;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    tile_fence_judge u0 (
        .clk(clk), .rst(rst), .start(start), .gen_sel(gen_sel),
        .tile_mode(tile_mode), .narrow_y(narrow_y), .stride(stride),
        .obj_size(obj_size), .region_size(region_size),
        .region_offset(region_offset), .done(done),
        .stride_ok(stride_ok), .fence_ok(fence_ok)
    );

    typedef struct packed {
        logic [1:0]  gen;
        logic [1:0]  mode;
        logic        nar;
        logic [15:0] stride;
        logic [31:0] obj;
        logic [31:0] rs;
        logic [31:0] off;
        logic        es;
        logic        ef;
        logic [7:0]  k;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [0:NV-1] = '{
        '{2'd0, 2'd0, 1'b0, 16'd100,   32'd5,          32'h0,          32'h3,          1'b1, 1'b1, 8'd0},  // R1
        '{2'd2, 2'd1, 1'b0, 16'd1024,  32'hFFFF_FFFF,  32'h0,          32'h1,          1'b1, 1'b1, 8'd0},  // R3 R6
        '{2'd2, 2'd1, 1'b0, 16'd640,   32'd10,         32'h0,          32'h0,          1'b0, 1'b1, 8'd0},  // R3
        '{2'd2, 2'd2, 1'b1, 16'd640,   32'd10,         32'h0,          32'h0,          1'b1, 1'b1, 8'd0},  // R2 R3
        '{2'd2, 2'd1, 1'b0, 16'd16384, 32'd10,         32'h0,          32'h0,          1'b0, 1'b1, 8'd0},  // R3
        '{2'd3, 2'd2, 1'b1, 16'd16256, 32'd10,         32'h0,          32'h0,          1'b1, 1'b1, 8'd0},  // R3 R6
        '{2'd0, 2'd1, 1'b0, 16'd512,   32'h0008_0000,  32'h0008_0000,  32'h0008_0000,  1'b1, 1'b1, 8'd0},  // R4 R7
        '{2'd0, 2'd1, 1'b0, 16'd64,    32'h0008_0001,  32'h0010_0000,  32'h0010_0000,  1'b0, 1'b1, 8'd1},  // R4 R7
        '{2'd1, 2'd1, 1'b0, 16'd512,   32'h0030_0000,  32'h0040_0000,  32'h00C0_0000,  1'b1, 1'b1, 8'd2},  // R7
        '{2'd1, 2'd1, 1'b0, 16'd768,   32'h0030_0000,  32'h0020_0000,  32'h0000_0000,  1'b0, 1'b0, 8'd2},  // R4 R7
        '{2'd1, 2'd2, 1'b1, 16'd128,   32'h0040_0000,  32'h0040_0000,  32'h0060_0000,  1'b1, 1'b0, 8'd2},  // R2 R7
        '{2'd1, 2'd1, 1'b0, 16'd16384, 32'd1,          32'h0010_0000,  32'h1000_0000,  1'b0, 1'b0, 8'd0},  // R4 R7
        '{2'd1, 2'd1, 1'b0, 16'd8192,  32'h0400_0000,  32'h0400_0000,  32'h0000_0000,  1'b1, 1'b1, 8'd6},  // R5 R7
        '{2'd1, 2'd1, 1'b0, 16'd8192,  32'h0400_0001,  32'h0800_0000,  32'h0000_0000,  1'b0, 1'b1, 8'd7},  // R5
        '{2'd0, 2'd2, 1'b1, 16'd128,   32'h0200_0001,  32'h0400_0000,  32'h0400_0000,  1'b0, 1'b1, 8'd7},  // R5 R7
        '{2'd0, 2'd1, 1'b0, 16'd256,   32'hFFFF_FFFF,  32'h8000_0000,  32'h0000_0000,  1'b0, 1'b0, 8'd12}, // R7 saturate
        '{2'd0, 2'd1, 1'b0, 16'd256,   32'h8000_0000,  32'h8000_0000,  32'h0000_0000,  1'b0, 1'b1, 8'd12}, // R5 R7
        '{2'd1, 2'd0, 1'b0, 16'd3,     32'hFFFF_FFFF,  32'h1234_5678,  32'h0000_0007,  1'b1, 1'b1, 8'd0},  // R1
        '{2'd0, 2'd1, 1'b0, 16'd128,   32'd1000,       32'h0008_0000,  32'h0000_0000,  1'b1, 1'b1, 8'd0},  // R2
        '{2'd1, 2'd1, 1'b0, 16'd256,   32'd1,          32'h0010_0000,  32'h0000_0000,  1'b0, 1'b1, 8'd0},  // R2
        '{2'd1, 2'd2, 1'b0, 16'd256,   32'd1,          32'h0010_0000,  32'h0000_0000,  1'b0, 1'b1, 8'd0},  // R2
        '{2'd1, 2'd3, 1'b1, 16'd128,   32'd1,          32'h0010_0000,  32'h0010_0000,  1'b1, 1'b1, 8'd0}   // R2 R7
    };

    task automatic chk(input bit cond, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        gen_sel = v.gen; tile_mode = v.mode; narrow_y = v.nar;
        stride = v.stride; obj_size = v.obj; region_size = v.rs;
        region_offset = v.off;
    endtask

    // assumes caller sets start at a negedge; returns negedges until done
    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int lat;
        drive(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(lat);
        chk(lat == int'(v.k) + 1, "R8", $sformatf("vec %0d latency", idx), 64'(lat), 64'(v.k + 1));
        chk(stride_ok == v.es, "R2-R5", $sformatf("vec %0d stride_ok", idx), 64'(stride_ok), 64'(v.es));
        chk(fence_ok == v.ef, "R6/R7", $sformatf("vec %0d fence_ok", idx), 64'(fence_ok), 64'(v.ef));
        @(negedge clk);
        chk(done == 1'b0, "R8", $sformatf("vec %0d done one cycle", idx), 64'(done), 64'd0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int lat;
        logic s_hold, f_hold;
        repeat (3) @(negedge clk);
        // R9: reset values
        chk(done == 0 && stride_ok == 0 && fence_ok == 0, "R9", "reset outputs",
            64'({done, stride_ok, fence_ok}), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(TBL[i], i);

        // R10: starts during a running judgement are dropped
        drive(TBL[13]);
        start = 1'b1;
        @(negedge clk);
        drive(TBL[0]);
        lat = 0;
        while (!done && lat < 40) begin
            if (lat >= 3) start = 1'b0;
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk(lat == 8, "R10", "busy start latency", 64'(lat), 64'd8);
        chk(stride_ok == 1'b0 && fence_ok == 1'b1, "R10", "busy start verdict",
            64'({stride_ok, fence_ok}), 64'b01);

        // R10: start in the done cycle is accepted
        drive(TBL[2]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(lat);
        chk(lat == 1, "R10", "done-cycle start latency", 64'(lat), 64'd1);
        chk(stride_ok == 1'b0 && fence_ok == 1'b1, "R10", "done-cycle start verdict",
            64'({stride_ok, fence_ok}), 64'b01);
        @(negedge clk);

        // R9: verdicts hold while inputs move and no start arrives
        s_hold = stride_ok; f_hold = fence_ok;
        drive(TBL[0]);
        repeat (5) @(negedge clk);
        chk(stride_ok == s_hold && fence_ok == f_hold && !done, "R9", "hold between pulses",
            64'({done, stride_ok, fence_ok}), 64'({1'b0, s_hold, f_hold}));

        // R9: reset in mid-run clears outputs and cancels the judgement
        drive(TBL[15]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(!done && !stride_ok && !fence_ok, "R9", "mid-run reset outputs",
            64'({done, stride_ok, fence_ok}), 64'd0);
        repeat (15) begin
            @(negedge clk);
            if (done) chk(1'b0, "R9", "done after reset", 64'd1, 64'd0);
        end
        chk(!done, "R9", "no late done after reset", 64'(done), 64'd0);

        // R1 after reset: fresh linear request works
        run_vec(TBL[17], 17);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule